// File: doc/BRIEF.md
# SDRAM Power-Down Sequencer

This block sits on the controller side of an SDR SDRAM interface and decides when the clock-enable pin goes low to put the memory into power-down, and when it comes back high. The main controller asks for a low-power idle period through a request line. The sequencer accepts the request only when nothing is in flight. While it holds the device down, it takes the command bus and keeps a NOP on it.

At entry the sequencer samples a per-bank open-row vector. It reports precharge power-down when every bank is idle, and active power-down when any row is open. The device cannot be refreshed while its clock is gated. A residency counter, sized from the clock frequency, the refresh period and a safety margin, therefore forces an exit before the refresh window closes. A refresh-due input also forces an immediate exit. After any exit, the sequencer keeps NOP with CKE high for a set number of clocks before it returns the bus to the controller.

Top module: `pdn_seq`

## Requirements
- R1: While reset is held and right after it, CKE is high, the bus is not owned (`busOwned`=0), the command is deselect (4'b1111), and the mode reads none (2'b00).
- R2: When the sequencer is running with `idleReq`=1, `accessBusy`=0 and `refreshDue`=0 at a clock edge, then after that edge CKE is low, `busOwned` is 1 and a NOP is on the bus.
- R3: An idle request that coincides with `accessBusy`=1 is refused: CKE stays high and the bus stays with the controller.
- R4: The mode is sampled at the entry edge: 2'b01 (precharge power-down) if `bankOpen` is all zero, and 2'b10 (active power-down) otherwise. It holds that value for the whole time CKE is low, whatever `bankOpen` does meanwhile.
- R5: The command output is {cs_n, ras_n, cas_n, we_n}. It is NOP (4'b0111) whenever the sequencer owns the bus, including the cycle in which CKE first falls, and deselect (4'b1111) otherwise.
- R6: When `idleReq` drops while CKE is low, CKE is high after the next edge, with NOP still driven and the mode back at 2'b00.
- R7: `refreshDue`=1 forces an exit from power-down at the next edge even while `idleReq` stays high, and it blocks any new entry.
- R8: CKE stays low for at most RES_CYCLES = CLK_MHZ*(REFRESH_US-MARGIN_US) consecutive cycles. With the request held, it rises after exactly that many.
- R9: After every exit, CKE is high with NOP and `busOwned`=1 for exactly EXIT_NOPS cycles (at least 1). Then `busOwned` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| idleReq | input | 1 | Request to hold the SDRAM in power-down |
| accessBusy | input | 1 | A read, write or other access is still in progress |
| refreshDue | input | 1 | A refresh must run; forces power-down to end |
| bankOpen | input | NUM_BANKS | One bit per bank, set while that bank has an open row |
| ckeOut | output | 1 | Clock-enable level for the SDRAM |
| cmdOut | output | 4 | {cs_n, ras_n, cas_n, we_n} offered while the sequencer owns the bus |
| busOwned | output | 1 | The sequencer owns the command bus; the controller must hold off |
| pdMode | output | 2 | 00 none, 01 precharge power-down, 10 active power-down |

## Verification
The bench checks that the mode latches at the entry edge and does not follow `bankOpen` afterwards. A design that sampled the vector continuously would flip from precharge to active in the middle of a power-down. It holds the idle request for the whole residency window and checks that CKE rises on the cycle after the limit, neither early nor late; an off-by-one counter shows up as one cycle too many or too few. It also raises refresh and drops the request during the single entry cycle, where a sequencer that always passes through the full power-down state would keep CKE low for one extra edge. Finally it checks the exit NOP period, so a design that returns the bus as soon as CKE rises fails the ownership check.

// File: rtl/pdn_pkg.sv
package pdn_pkg;

  typedef enum logic [1:0] {
    PD_NONE      = 2'b00,
    PD_PRECHARGE = 2'b01,
    PD_ACTIVE    = 2'b10
  } pdMode_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_ENTER,
    ST_DOWN,
    ST_EXIT
  } seqState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic resCntEn;   // count residency while CKE is low
    logic exitCntEn;  // count exit NOP cycles
    logic modeLoad;   // sample bank state at entry edge
    logic modeClr;    // clear mode on leaving power-down
  } pdnStrobe_t;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP      = 4'b0111;
  localparam logic [3:0] CMD_DESELECT = 4'b1111;

endpackage

// File: rtl/pdn_timer.sv
module pdn_timer
  import pdn_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int RES_CYCLES = 1000,
  parameter int EXIT_NOPS  = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pdnStrobe_t           strobe,
  input  logic [NUM_BANKS-1:0] bankOpen,
  output logic                 resLimit,
  output logic                 exitDone,
  output logic [1:0]           pdMode
);

  localparam int RES_W  = $clog2(RES_CYCLES + 1);
  localparam int EXIT_W = $clog2(EXIT_NOPS + 1);
  localparam logic [RES_W-1:0]  RES_LAST  = RES_W'(RES_CYCLES - 1);
  localparam logic [EXIT_W-1:0] EXIT_LAST = EXIT_W'(EXIT_NOPS - 1);

  logic [RES_W-1:0]  resCnt;
  logic [EXIT_W-1:0] exitCnt;
  pdMode_e           modeQ;

  always_ff @(posedge clk) begin
    if (!rstN || !strobe.resCntEn) resCnt <= '0;
    else                           resCnt <= resCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strobe.exitCntEn) exitCnt <= '0;
    else                            exitCnt <= exitCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                modeQ <= PD_NONE;
    else if (strobe.modeLoad) modeQ <= (|bankOpen) ? PD_ACTIVE : PD_PRECHARGE;
    else if (strobe.modeClr)  modeQ <= PD_NONE;
  end

  assign resLimit = strobe.resCntEn && (resCnt == RES_LAST);
  assign exitDone = strobe.exitCntEn && (exitCnt == EXIT_LAST);
  assign pdMode   = modeQ;

  // R4: mode does not move while power-down continues
  a_r4_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.resCntEn && $past(strobe.resCntEn)) |-> $stable(pdMode));

endmodule

// File: rtl/pdn_ctrl.sv
module pdn_ctrl
  import pdn_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       idleReq,
  input  logic       accessBusy,
  input  logic       refreshDue,
  input  logic       resLimit,
  input  logic       exitDone,
  output pdnStrobe_t strobe,
  output logic       ckeOut,
  output logic       busOwned,
  output logic [3:0] cmdOut
);

  seqState_e state, stateNext;
  logic      lowPhase;
  logic      leaveLow;

  assign lowPhase = (state == ST_ENTER) || (state == ST_DOWN);
  assign leaveLow = refreshDue || !idleReq || resLimit;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUN:   if (idleReq && !accessBusy && !refreshDue) stateNext = ST_ENTER;
      ST_ENTER,
      ST_DOWN:  stateNext = leaveLow ? ST_EXIT : ST_DOWN;
      ST_EXIT:  if (exitDone) stateNext = ST_RUN;
      default:  stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.resCntEn  = lowPhase;
    strobe.exitCntEn = (state == ST_EXIT);
    strobe.modeLoad  = (state == ST_RUN) && (stateNext == ST_ENTER);
    strobe.modeClr   = lowPhase && (stateNext == ST_EXIT);
  end

  assign ckeOut   = !lowPhase;
  assign busOwned = (state != ST_RUN);
  assign cmdOut   = busOwned ? CMD_NOP : CMD_DESELECT;

  // R2: an accepted request drops CKE at the next edge
  a_r2_enter: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && idleReq && !accessBusy && !refreshDue) |=> !ckeOut);

  // R3: busy at request time keeps the bus with the controller
  a_r3_refuse: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && accessBusy) |=> (ckeOut && !busOwned));

  // R5: CKE falls only with a NOP on the bus
  a_r5_nop_at_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ckeOut) |-> (cmdOut == CMD_NOP));

  // R7: refresh due ends power-down at the next edge
  a_r7_refresh_exit: assert property (@(posedge clk) disable iff (!rstN)
    (refreshDue && !ckeOut) |=> ckeOut);

  // R8: residency limit from the datapath ends power-down
  a_r8_res_exit: assert property (@(posedge clk) disable iff (!rstN)
    (resLimit && !ckeOut) |=> ckeOut);

  // R9: CKE rises while the sequencer still owns the bus
  a_r9_exit_owned: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ckeOut) |-> busOwned);

  // R9: exit period not yet done keeps NOP with CKE high
  a_r9_exit_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EXIT && !exitDone) |=> (busOwned && ckeOut));

endmodule

// File: rtl/pdn_seq.sv
module pdn_seq
  import pdn_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int CLK_MHZ    = 143,
  parameter int REFRESH_US = 64000,
  parameter int MARGIN_US  = 1000,
  parameter int EXIT_NOPS  = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 idleReq,
  input  logic                 accessBusy,
  input  logic                 refreshDue,
  input  logic [NUM_BANKS-1:0] bankOpen,
  output logic                 ckeOut,
  output logic [3:0]           cmdOut,
  output logic                 busOwned,
  output logic [1:0]           pdMode
);

  localparam int RES_CYCLES = CLK_MHZ * (REFRESH_US - MARGIN_US);

  pdnStrobe_t strobe;
  logic       resLimit;
  logic       exitDone;

  pdn_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .idleReq    (idleReq),
    .accessBusy (accessBusy),
    .refreshDue (refreshDue),
    .resLimit   (resLimit),
    .exitDone   (exitDone),
    .strobe     (strobe),
    .ckeOut     (ckeOut),
    .busOwned   (busOwned),
    .cmdOut     (cmdOut)
  );

  pdn_timer #(
    .NUM_BANKS  (NUM_BANKS),
    .RES_CYCLES (RES_CYCLES),
    .EXIT_NOPS  (EXIT_NOPS)
  ) i_timer (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .bankOpen (bankOpen),
    .resLimit (resLimit),
    .exitDone (exitDone),
    .pdMode   (pdMode)
  );

endmodule

// File: tb/test_pdn_seq.sv
module test_pdn_seq;

  localparam int NB = 4;
  localparam int RES = 30;   // 1 MHz * (40 - 10) us
  localparam int XN = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic idleReq = 1'b0, accessBusy = 1'b0, refreshDue = 1'b0;
  logic [NB-1:0] bankOpen = '0;
  logic ckeOut, busOwned;
  logic [3:0] cmdOut;
  logic [1:0] pdMode;

  int nTests = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  pdn_seq #(
    .NUM_BANKS(NB), .CLK_MHZ(1), .REFRESH_US(40), .MARGIN_US(10), .EXIT_NOPS(XN)
  ) i_pdn_seq (
    .clk(clk), .rstN(rstN), .idleReq(idleReq), .accessBusy(accessBusy),
    .refreshDue(refreshDue), .bankOpen(bankOpen), .ckeOut(ckeOut),
    .cmdOut(cmdOut), .busOwned(busOwned), .pdMode(pdMode)
  );

  typedef struct {
    logic       cke;
    logic       own;
    logic [1:0] mode;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t monItem;

  task automatic checkAll(input logic eCke, input logic eOwn, input logic [1:0] eMode,
                          input string tag);
    logic [3:0] eCmd;
    eCmd = eOwn ? 4'b0111 : 4'b1111;
    nTests++;
    if (ckeOut !== eCke || busOwned !== eOwn || pdMode !== eMode || cmdOut !== eCmd) begin
      nFail++;
      $display("FAIL %s: cke/own/mode/cmd actual %b/%b/%b/%b expected %b/%b/%b/%b",
               tag, ckeOut, busOwned, pdMode, cmdOut, eCke, eOwn, eMode, eCmd);
    end
  endtask

  // monitor: compare just after each active edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      monItem = expQ.pop_front();
      checkAll(monItem.cke, monItem.own, monItem.mode, monItem.tag);
    end
  end

  // driver: apply inputs for the next edge and queue the outcome
  task automatic step(input logic idle, input logic busy, input logic refr,
                      input logic [NB-1:0] banks, input logic eCke, input logic eOwn,
                      input logic [1:0] eMode, input string tag);
    expItem_t it;
    @(negedge clk);
    idleReq = idle; accessBusy = busy; refreshDue = refr; bankOpen = banks;
    it.cke = eCke; it.own = eOwn; it.mode = eMode; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkAll(1'b1, 1'b0, 2'b00, "R1 in reset");
    rstN = 1'b1;
    @(posedge clk); #1;
    checkAll(1'b1, 1'b0, 2'b00, "R1 after reset");

    // precharge power-down, bank change ignored, exit on request drop
    step(1, 0, 0, 4'b0000, 0, 1, 2'b01, "R2 R4 R5 enter precharge");
    step(1, 0, 0, 4'b0000, 0, 1, 2'b01, "R2 stay down");
    step(1, 0, 0, 4'b0100, 0, 1, 2'b01, "R4 mode held");
    step(0, 0, 0, 4'b0100, 1, 1, 2'b00, "R6 exit on drop");
    step(0, 0, 0, 4'b0000, 1, 1, 2'b00, "R9 exit nop 2");
    step(0, 0, 0, 4'b0000, 1, 0, 2'b00, "R9 bus returned");

    // refusals
    step(1, 1, 0, 4'b0000, 1, 0, 2'b00, "R3 busy refuses");
    step(1, 0, 1, 4'b0000, 1, 0, 2'b00, "R7 refresh blocks entry");

    // active power-down, forced out by refresh
    step(1, 0, 0, 4'b0001, 0, 1, 2'b10, "R4 enter active");
    step(1, 0, 0, 4'b0000, 0, 1, 2'b10, "R4 active held");
    step(1, 0, 1, 4'b0000, 1, 1, 2'b00, "R7 refresh exit");
    step(1, 0, 1, 4'b0000, 1, 1, 2'b00, "R9 exit nop 2");
    step(1, 0, 1, 4'b0000, 1, 0, 2'b00, "R9 bus returned");
    step(1, 0, 1, 4'b0000, 1, 0, 2'b00, "R7 refresh still blocks");
    step(0, 0, 0, 4'b0000, 1, 0, 2'b00, "R1 idle");

    // residency limit
    step(1, 0, 0, 4'b0000, 0, 1, 2'b01, "R8 enter");
    for (int i = 1; i < RES; i++)
      step(1, 0, 0, 4'b0000, 0, 1, 2'b01, "R8 within limit");
    step(1, 0, 0, 4'b0000, 1, 1, 2'b00, "R8 forced exit");
    step(0, 0, 0, 4'b0000, 1, 1, 2'b00, "R9 exit nop 2");
    step(0, 0, 0, 4'b0000, 1, 0, 2'b00, "R9 bus returned");

    // exits straight from the entry cycle
    step(1, 0, 0, 4'b1000, 0, 1, 2'b10, "R2 enter");
    step(1, 0, 1, 4'b0000, 1, 1, 2'b00, "R7 refresh in entry cycle");
    step(0, 0, 0, 4'b0000, 1, 1, 2'b00, "R9 exit nop 2");
    step(0, 0, 0, 4'b0000, 1, 0, 2'b00, "R9 bus returned");
    step(1, 0, 0, 4'b0000, 0, 1, 2'b01, "R2 enter");
    step(0, 0, 0, 4'b0000, 1, 1, 2'b00, "R6 drop in entry cycle");
    step(0, 0, 0, 4'b0000, 1, 1, 2'b00, "R9 exit nop 2");
    step(0, 0, 0, 4'b0000, 1, 0, 2'b00, "R9 bus returned");

    repeat (3) @(posedge clk);
    #2;
    finishRun();
  end

endmodule